// File: doc/BRIEF.md
# Error Status Collector with Maskable Error Interrupt

This block gathers error events raised elsewhere in an interrupt controller and keeps them in a software-visible status register. Each event input sets its own bit. The bit stays set until software clears the register with a write. Every newly recorded error can also raise a one-cycle error-interrupt request. That request is gated by the mask bit of the error entry in the local vector table. Capture of the error itself does not depend on the mask.

The block follows the controller's addressing mode. In legacy mode, any write clears the register. A separate illegal-register-access pulse is recorded in a dedicated status bit, because in this mode an illegal access is reported in the register and does not fault. In extended mode, only a write of zero is legal. A nonzero write raises a one-cycle fault flag and leaves the register unchanged.

Reads are strobed, and the read value is registered. Event inputs are single-cycle pulses, and more than one may arrive in the same cycle.

Top module: `err_status_unit`

## Requirements
- R1: After synchronous reset, the status register is zero, and `rd_data`, `err_irq` and `wr_fault` are all 0.
- R2: A pulse on `err_evt[i]` sets status bit i. Bits are sticky and accumulate by OR across events until a clearing write.
- R3: Events are recorded whether `err_mask` is 0 or 1.
- R4: `err_irq` is high for exactly the one cycle after a clock edge at which at least one status bit newly becomes set, and only if `err_mask` was 0 at that edge.
- R5: An event on a bit that is already set, with no clearing write at the same edge, raises no interrupt.
- R6: In extended mode (`ext_mode`=1), writing zero clears the status register and does not raise `wr_fault`.
- R7: In extended mode, a nonzero write raises `wr_fault` for exactly the next cycle and leaves the status register unchanged.
- R8: In legacy mode (`ext_mode`=0), a write of any value clears the status register and never raises `wr_fault`.
- R9: A pulse on `illegal_acc` sets status bit 7 (parameter ILL_IDX) in legacy mode. In extended mode the pulse is ignored.
- R10: An event that coincides with a clearing write is kept in the register after the clear. It counts as a new error for R4.
- R11: When `rd_en` is high at an edge, `rd_data` shows, from the next cycle on, the status as it was before that edge, zero-extended to DATA_W bits. When `rd_en` is low, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt | input | NUM_ERR (8) | Error event pulses, bit i sets status bit i |
| illegal_acc | input | 1 | Illegal register access pulse, recorded only in legacy mode |
| ext_mode | input | 1 | 1 = extended mode, 0 = legacy mode |
| err_mask | input | 1 | Mask bit of the error vector-table entry |
| wr_en | input | 1 | Write strobe for the status register |
| wr_data | input | DATA_W (32) | Write value |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Registered read value |
| err_irq | output | 1 | One-cycle error-interrupt request |
| wr_fault | output | 1 | One-cycle fault flag for an illegal write |

## Verification
Every result of this block is due one cycle after the edge that samples its stimulus. This holds for the read value, the interrupt pulse and the fault flag, since each is a single register past the decision logic. The bench drives each stimulus just after a falling edge. At the same moment it pushes the outputs that the requirements predict for the next rising edge. A monitor checks them a quarter period after that rising edge, so every comparison lands in the single cycle in which the pulse outputs are valid. A pulse that comes early, late or lasts two cycles therefore shows up as a mismatch on a neighbouring cycle.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;

  // Outcome of one write attempt to the status register
  typedef struct packed {
    logic clear;   // write accepted, register cleared
    logic fault;   // write rejected
  } wr_verdict_t;

  // Legality of a write under the current mode
  function automatic wr_verdict_t judge_write(input logic wr, input logic ext,
                                              input logic nonzero);
    wr_verdict_t v;
    v.clear = wr & (~ext | ~nonzero);
    v.fault = wr & ext & nonzero;
    return v;
  endfunction

endpackage

// File: rtl/err_write_guard.sv
module err_write_guard
  import err_stat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ext_mode_i,
  output logic              clear_o,
  output logic              fault_o
);

  wr_verdict_t verdict;
  logic        fault_q;

  always_comb begin
    verdict = judge_write(wr_en_i, ext_mode_i, |wr_data_i);
  end

  assign clear_o = verdict.clear;

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= verdict.fault;
  end

  assign fault_o = fault_q;

  // R8
  legacy_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !ext_mode_i) |=> !fault_o);

  // R7
  fault_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i) |=> !fault_o);

endmodule

// File: rtl/err_event_capture.sv
module err_event_capture #(
  parameter int NUM_ERR = 8,
  parameter int ILL_IDX = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] evt_i,
  input  logic               ill_i,
  input  logic               ext_mode_i,
  input  logic               clr_i,
  output logic [NUM_ERR-1:0] status_o,
  output logic [NUM_ERR-1:0] new_o
);

  logic [NUM_ERR-1:0] set_vec;
  logic [NUM_ERR-1:0] status_q;

  for (genvar b = 0; b < NUM_ERR; b++) begin : g_bit
    logic hit;
    if (b == ILL_IDX) begin : g_ill
      assign hit = evt_i[b] | (ill_i & ~ext_mode_i);
    end else begin : g_plain
      assign hit = evt_i[b];
    end
    assign set_vec[b] = hit;
    // a bit is new when hit and not already held past this edge
    assign new_o[b]   = hit & (clr_i | ~status_q[b]);

    always_ff @(posedge clk) begin
      if (rst)        status_q[b] <= 1'b0;
      else if (clr_i) status_q[b] <= hit;
      else if (hit)   status_q[b] <= 1'b1;
    end
  end

  assign status_o = status_q;

  // R2
  sticky_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R10
  clear_keeps_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (evt_i != '0)) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R9
  ext_ill_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_mode_i && ill_i && !evt_i[ILL_IDX] && !status_q[ILL_IDX]) |=> !status_q[ILL_IDX]);

endmodule

// File: rtl/err_irq_gen.sv
module err_irq_gen #(
  parameter int NUM_ERR = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] new_i,
  input  logic               mask_i,
  output logic               irq_o
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (|new_i) & ~mask_i;
  end

  assign irq_o = irq_q;

  // R4
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mask_i |=> !irq_o);

  // R5
  no_new_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (new_i == '0) |=> !irq_o);

endmodule

// File: rtl/err_status_unit.sv
module err_status_unit #(
  parameter int DATA_W  = 32,
  parameter int NUM_ERR = 8,
  parameter int ILL_IDX = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] err_evt,
  input  logic               illegal_acc,
  input  logic               ext_mode,
  input  logic               err_mask,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  output logic               err_irq,
  output logic               wr_fault
);

  localparam int PAD_W = DATA_W - NUM_ERR;

  logic               clr;
  logic [NUM_ERR-1:0] status;
  logic [NUM_ERR-1:0] new_bits;
  logic [DATA_W-1:0]  rd_q;

  err_write_guard #(.DATA_W(DATA_W)) u_guard (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .ext_mode_i (ext_mode),
    .clear_o    (clr),
    .fault_o    (wr_fault)
  );

  err_event_capture #(.NUM_ERR(NUM_ERR), .ILL_IDX(ILL_IDX)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (err_evt),
    .ill_i      (illegal_acc),
    .ext_mode_i (ext_mode),
    .clr_i      (clr),
    .status_o   (status),
    .new_o      (new_bits)
  );

  err_irq_gen #(.NUM_ERR(NUM_ERR)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .new_i  (new_bits),
    .mask_i (err_mask),
    .irq_o  (err_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= {{PAD_W{1'b0}}, status};
  end

  assign rd_data = rd_q;

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> $stable(rd_data));

  // R11
  rd_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:NUM_ERR] == '0);

  // R7
  fault_ext_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_mode) |=> !wr_fault);

endmodule

// File: tb/err_status_unit_test.sv
module err_status_unit_test;

  localparam int DW = 32;
  localparam int NE = 8;
  localparam int ILL = 7;

  typedef struct {
    string       tag;
    logic [DW-1:0] rd;
    logic        irq;
    logic        flt;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] err_evt = '0;
  logic          illegal_acc = 1'b0;
  logic          ext_mode = 1'b0;
  logic          err_mask = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          err_irq;
  logic          wr_fault;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  exp_t sb[$];

  // reference state derived from the requirements
  logic [NE-1:0] m_stat = '0;
  logic [DW-1:0] m_rd = '0;

  always #10 clk = ~clk;

  err_status_unit #(.DATA_W(DW), .NUM_ERR(NE), .ILL_IDX(ILL)) uut (
    .clk(clk), .rst(rst), .err_evt(err_evt), .illegal_acc(illegal_acc),
    .ext_mode(ext_mode), .err_mask(err_mask), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .err_irq(err_irq), .wr_fault(wr_fault)
  );

  task automatic step(input string tag, input logic [NE-1:0] evt, input logic ill,
                      input logic ext, input logic msk, input logic wr,
                      input logic [DW-1:0] wd, input logic rd);
    exp_t e;
    logic [NE-1:0] setv, newv;
    logic clr, flt;
    @(negedge clk);
    err_evt = evt; illegal_acc = ill; ext_mode = ext; err_mask = msk;
    wr_en = wr; wr_data = wd; rd_en = rd;
    setv = evt;
    if (ill && !ext) setv[ILL] = 1'b1;
    clr = wr && (!ext || wd == '0);
    flt = wr && ext && (wd != '0);
    newv = setv & (clr ? {NE{1'b1}} : ~m_stat);
    if (rd) m_rd = {{(DW-NE){1'b0}}, m_stat};
    m_stat = clr ? setv : (m_stat | setv);
    e.tag = tag; e.rd = m_rd; e.irq = (|newv) && !msk; e.flt = flt;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag, input logic rd);
    step(tag, '0, 1'b0, ext_mode, err_mask, 1'b0, '0, rd);
  endtask

  // monitor: a quarter period after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        compared++;
        if (rd_data !== e.rd || err_irq !== e.irq || wr_fault !== e.flt) begin
          mismatched++;
          $display("FAIL %s: rd=%h irq=%b flt=%b expected rd=%h irq=%b flt=%b",
                   e.tag, rd_data, err_irq, wr_fault, e.rd, e.irq, e.flt);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    idle("R1", 1'b1);
    idle("R1", 1'b0);
    // R2: accumulate by OR
    step("R2", 8'h01, 0, 0, 0, 0, '0, 0);
    step("R2", 8'h08, 0, 0, 0, 0, '0, 0);
    idle("R2", 1'b1);
    idle("R2", 1'b0);
    // R3: masked event still captured, no irq (R4)
    step("R3", 8'h20, 0, 0, 1, 0, '0, 0);
    step("R3", 8'h00, 0, 0, 1, 0, '0, 1);
    idle("R3", 1'b0);
    // R5: repeat on a set bit, unmasked
    step("R5", 8'h01, 0, 0, 0, 0, '0, 0);
    idle("R5", 1'b0);
    // R4: new bit unmasked pulses once
    step("R4", 8'h02, 0, 0, 0, 0, '0, 0);
    idle("R4", 1'b0);
    idle("R4", 1'b1);
    // R7: nonzero write in extended mode
    step("R7", 8'h00, 0, 1, 0, 1, 32'h0000_0055, 0);
    idle("R7", 1'b1);
    idle("R7", 1'b0);
    // R6: zero write clears in extended mode
    step("R6", 8'h00, 0, 1, 0, 1, 32'h0, 0);
    idle("R6", 1'b1);
    idle("R6", 1'b0);
    // R9: illegal access ignored in extended mode, recorded in legacy mode
    step("R9", 8'h00, 1, 1, 0, 0, '0, 0);
    idle("R9", 1'b1);
    step("R9", 8'h00, 1, 0, 0, 0, '0, 0);
    idle("R9", 1'b1);
    idle("R9", 1'b0);
    // R8: legacy write of any value clears, no fault
    step("R8", 8'h00, 0, 0, 0, 1, 32'hFFFF_FFFF, 0);
    idle("R8", 1'b1);
    step("R8", 8'h10, 0, 0, 0, 0, '0, 0);
    step("R8", 8'h00, 0, 0, 0, 1, 32'h0, 1);
    idle("R8", 1'b1);
    // R10: event coincides with clearing write
    step("R10", 8'h04, 0, 0, 1, 0, '0, 0);
    step("R10", 8'h04, 0, 0, 0, 1, 32'h1234, 0);
    idle("R10", 1'b1);
    step("R10", 8'h40, 0, 1, 0, 1, 32'h0, 0);
    idle("R10", 1'b1);
    // R11: read coinciding with a write returns old value
    step("R11", 8'h00, 0, 0, 0, 1, 32'h7, 1);
    idle("R11", 1'b1);
    // R4: walking single events, each new, back to back
    for (int i = 0; i < NE; i++) step("R4", NE'(1) << i, 0, 0, 0, 0, '0, 0);
    idle("R2", 1'b1);
    idle("R2", 1'b0);
    // R3 and R4: multiple bits at once masked, then unmasked repeat is not new
    step("R3", 8'h00, 0, 1, 0, 1, 32'h0, 0);
    step("R3", 8'hA5, 0, 1, 1, 0, '0, 0);
    step("R5", 8'hA5, 0, 1, 0, 0, '0, 1);
    idle("R5", 1'b1);
    // R7: fault leaves multi-bit status intact
    step("R7", 8'h00, 0, 1, 0, 1, 32'h8000_0000, 0);
    idle("R7", 1'b1);
    idle("R7", 1'b0);
    @(negedge clk);
    err_evt = '0; wr_en = 1'b0; rd_en = 1'b0; illegal_acc = 1'b0;
    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule